// File: doc/BRIEF.md
# Vector gather micro-op sequencer

This block turns one decoded register-gather vector instruction into a stream of simple micro-ops. A gather over a register group of N registers can pull any element of any of the N data registers into any destination register. Executing that as one operation would need every data register read at once. Instead, the sequencer emits N×N micro-ops, each of which reads exactly one data register. Each micro-op also reads the index register for its destination and the old value of that destination, and merges the result into it. This way the register file never needs partial writes, and each micro-op reads at most four registers (data, index, old destination, mask).

The micro-ops are emitted one per cycle on a valid/ready handshake, ordered destination by destination. Micro-ops aimed at different destinations are independent of one another. Those aimed at the same destination form a chain through the old-destination operand, so the first and last tags mark the boundaries of each chain. A build-time option widens each micro-op to two data registers, which brings the count down to N×⌈N/2⌉. A new instruction is taken only while the block is idle.

Top module: `gather_useq`

## Requirements
- R1: For a group multiplier code c on `in_lmul` (0→N=1, 1→N=2, 2→N=4, 3→N=8), the single-source build emits exactly N×N micro-ops, and `done` is high only during the handshake of the final one.
- R2: Micro-ops are destination-major: destination offset d runs 0..N-1; within each d, the slice number on `out_slice` steps 0,1,..,N-1 and the data register is data base + slice.
- R3: The index register of every micro-op equals index base + d, the same offset as its destination.
- R4: The old-destination register of every micro-op equals its destination register.
- R5: When `in_mask_en` was 1 at acceptance, every micro-op has `out_vmask_vld`=1 with `out_vmask`=register 0; otherwise `out_vmask_vld`=0.
- R6: `out_first` is 1 exactly on slice 0 of each destination, and `out_last` is 1 exactly on the final micro-op of each destination.
- R7: While `out_valid` is high and `out_ready` is low, the presented micro-op is held unchanged in the next cycle.
- R8: `in_ready` is 1 only when idle; an `in_valid` pulse while busy is ignored and does not change the running stream.
- R9: In the paired build, the slice steps by 2, `out_vs1` = data base + slice + 1 with `out_vs1_vld`=1 when slice+1 < N, and the count is N×⌈N/2⌉.
- R10: All register numbers are base + offset modulo 32.
- R11: After reset, `out_valid`=0, `busy`=0, `done`=0 and `in_ready`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Instruction present |
| in_ready | output | 1 | Sequencer idle, instruction will be taken |
| in_vd | input | 5 | Destination base register |
| in_vs | input | 5 | Data-source base register |
| in_vi | input | 5 | Index base register |
| in_lmul | input | 2 | Group multiplier code (N = 1 << code) |
| in_mask_en | input | 1 | Masked instruction |
| out_valid | output | 1 | Micro-op present |
| out_ready | input | 1 | Downstream takes the micro-op |
| out_vd | output | 5 | Destination register |
| out_vs0 | output | 5 | First data-source register |
| out_vs1 | output | 5 | Second data-source register (paired build) |
| out_vs1_vld | output | 1 | Second data source in use |
| out_vidx | output | 5 | Index register |
| out_vold | output | 5 | Old-destination source register |
| out_vmask | output | 5 | Mask register |
| out_vmask_vld | output | 1 | Mask source in use |
| out_slice | output | 3 | Source slice number of the first data register |
| out_first | output | 1 | First micro-op of its destination |
| out_last | output | 1 | Last micro-op of its destination |
| busy | output | 1 | Instruction in progress |
| done | output | 1 | Final micro-op handshake of the instruction |

## Verification
The bench builds two copies: the default single-source build and the paired build. The paired build reaches the two-register micro-op, the step of two, and the odd trailing case where N=1 leaves the second source unused. Both copies see every multiplier code, bases that wrap past register 31, masked and unmasked instructions, and downstream stall patterns. A directed case also drives an instruction pulse while busy.

// File: rtl/gus_pkg.sv
package gus_pkg;
   localparam int REG_AW     = 5;
   localparam int LMUL_CW    = 2;
   localparam int MAX_LMUL   = 1 << ((1 << LMUL_CW) - 1);
   localparam int OFF_W      = $clog2(MAX_LMUL);

   typedef logic [REG_AW-1:0] vreg_t;
   typedef logic [OFF_W-1:0]  voff_t;

   function automatic voff_t lmul_last(input logic [LMUL_CW-1:0] code);
      return voff_t'((1 << code) - 1);
   endfunction
endpackage

// File: rtl/gus_walk.sv
module gus_walk #(
   parameter int OFF_W = 3,
   parameter int STEP  = 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic [OFF_W-1:0] nm1,
   input  logic             adv,
   output logic             busy,
   output logic [OFF_W-1:0] d,
   output logic [OFF_W-1:0] s,
   output logic             grp_last,
   output logic             ins_last
);
   localparam int SW = OFF_W + 1;

   if (STEP < 1 || STEP > 2) begin : g_bad_step
      $error("gus_walk: STEP must be 1 or 2");
   end

   logic [SW-1:0] s_nxt_w;

   assign s_nxt_w  = {1'b0, s} + SW'(STEP);
   assign grp_last = s_nxt_w > {1'b0, nm1};
   assign ins_last = grp_last && (d == nm1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy <= 1'b0;
         d    <= '0;
         s    <= '0;
      end else if (start) begin
         busy <= 1'b1;
         d    <= '0;
         s    <= '0;
      end else if (adv) begin
         if (grp_last) begin
            s <= '0;
            if (ins_last) busy <= 1'b0;
            else          d    <= d + 1'b1;
         end else begin
            s <= s_nxt_w[OFF_W-1:0];
         end
      end
   end

   // R2: inside one destination the slice advances by the step and d holds
   a_r2_slice_step: assert property (@(posedge clk) disable iff (!rst_n)
      (adv && busy && !grp_last) |=> (s == $past(s) + OFF_W'(STEP)) && (d == $past(d)));
   // R6: leaving a destination restarts the slice at zero
   a_r6_group_restart: assert property (@(posedge clk) disable iff (!rst_n)
      (adv && busy && grp_last && !ins_last) |=> (s == '0) && (d == $past(d) + 1'b1));
endmodule

// File: rtl/gus_uop_fmt.sv
module gus_uop_fmt #(
   parameter int REG_AW   = 5,
   parameter int OFF_W    = 3,
   parameter bit PAIR_SRC = 1'b0,
   parameter int MASK_REG = 0
) (
   input  logic [REG_AW-1:0] bd,
   input  logic [REG_AW-1:0] bs,
   input  logic [REG_AW-1:0] bi,
   input  logic [OFF_W-1:0]  d,
   input  logic [OFF_W-1:0]  s,
   input  logic [OFF_W-1:0]  nm1,
   input  logic              mask_en,
   output logic [REG_AW-1:0] vd,
   output logic [REG_AW-1:0] vs0,
   output logic [REG_AW-1:0] vs1,
   output logic              vs1_vld,
   output logic [REG_AW-1:0] vidx,
   output logic [REG_AW-1:0] vold,
   output logic [REG_AW-1:0] vmask,
   output logic              vmask_vld
);
   if (REG_AW < OFF_W) begin : g_bad_aw
      $error("gus_uop_fmt: register field narrower than offset");
   end

   always_comb begin
      vd        = bd + REG_AW'(d);
      vs0       = bs + REG_AW'(s);
      vidx      = bi + REG_AW'(d);
      vold      = vd;
      vmask     = REG_AW'(MASK_REG);
      vmask_vld = mask_en;
   end

   if (PAIR_SRC) begin : g_pair
      logic [OFF_W:0] s_up;
      assign s_up    = {1'b0, s} + 1'b1;
      assign vs1     = bs + REG_AW'(s) + 1'b1;
      assign vs1_vld = s_up <= {1'b0, nm1};
   end else begin : g_single
      assign vs1     = '0;
      assign vs1_vld = 1'b0;
   end
endmodule

// File: rtl/gather_useq.sv
module gather_useq
   import gus_pkg::*;
#(
   parameter bit PAIR_SRC = 1'b0,
   parameter int MASK_REG = 0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   output logic              in_ready,
   input  logic [REG_AW-1:0] in_vd,
   input  logic [REG_AW-1:0] in_vs,
   input  logic [REG_AW-1:0] in_vi,
   input  logic [LMUL_CW-1:0] in_lmul,
   input  logic              in_mask_en,
   output logic              out_valid,
   input  logic              out_ready,
   output logic [REG_AW-1:0] out_vd,
   output logic [REG_AW-1:0] out_vs0,
   output logic [REG_AW-1:0] out_vs1,
   output logic              out_vs1_vld,
   output logic [REG_AW-1:0] out_vidx,
   output logic [REG_AW-1:0] out_vold,
   output logic [REG_AW-1:0] out_vmask,
   output logic              out_vmask_vld,
   output logic [OFF_W-1:0]  out_slice,
   output logic              out_first,
   output logic              out_last,
   output logic              busy,
   output logic              done
);
   localparam int STEP  = PAIR_SRC ? 2 : 1;
   localparam int CNT_W = 2 * OFF_W + 1;

   if (MASK_REG < 0 || MASK_REG >= (1 << REG_AW)) begin : g_bad_mask
      $error("gather_useq: MASK_REG out of range");
   end

   vreg_t bd_q, bs_q, bi_q;
   voff_t nm1_q;
   logic  mask_q;
   voff_t d_w, s_w;
   logic  grp_last_w, ins_last_w, start_w, fire_w;

   assign in_ready  = !busy;
   assign start_w   = in_valid && in_ready;
   assign out_valid = busy;
   assign fire_w    = out_valid && out_ready;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         bd_q   <= '0;
         bs_q   <= '0;
         bi_q   <= '0;
         nm1_q  <= '0;
         mask_q <= 1'b0;
      end else if (start_w) begin
         bd_q   <= in_vd;
         bs_q   <= in_vs;
         bi_q   <= in_vi;
         nm1_q  <= lmul_last(in_lmul);
         mask_q <= in_mask_en;
      end
   end

   gus_walk #(.OFF_W(OFF_W), .STEP(STEP)) walk_i (
      .clk(clk), .rst_n(rst_n), .start(start_w), .nm1(nm1_q), .adv(fire_w),
      .busy(busy), .d(d_w), .s(s_w), .grp_last(grp_last_w), .ins_last(ins_last_w)
   );

   gus_uop_fmt #(.REG_AW(REG_AW), .OFF_W(OFF_W), .PAIR_SRC(PAIR_SRC), .MASK_REG(MASK_REG)) fmt_i (
      .bd(bd_q), .bs(bs_q), .bi(bi_q), .d(d_w), .s(s_w), .nm1(nm1_q), .mask_en(mask_q),
      .vd(out_vd), .vs0(out_vs0), .vs1(out_vs1), .vs1_vld(out_vs1_vld),
      .vidx(out_vidx), .vold(out_vold), .vmask(out_vmask), .vmask_vld(out_vmask_vld)
   );

   assign out_slice = s_w;
   assign out_first = busy && (s_w == '0);
   assign out_last  = busy && grp_last_w;
   assign done      = fire_w && ins_last_w;

   // Independent tally of handshakes for the count property
   logic [CNT_W-1:0] emitted_q;
   logic [CNT_W-1:0] expect_w;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       emitted_q <= '0;
      else if (start_w) emitted_q <= '0;
      else if (fire_w)  emitted_q <= emitted_q + 1'b1;
   end
   assign expect_w = CNT_W'((int'(nm1_q) + 1) * ((int'(nm1_q) + STEP) / STEP));

   // R1 / R9: the final handshake is the expected count
   a_r1_uop_count: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (emitted_q + 1'b1) == expect_w);
   // R7: a stalled micro-op is held
   a_r7_stall_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_ready) |=> out_valid && $stable(out_vd) && $stable(out_vs0)
                                    && $stable(out_vidx) && $stable(out_slice));
   // R3: index register is constant within one destination
   a_r3_index_fixed: assert property (@(posedge clk) disable iff (!rst_n)
      (fire_w && !out_last) |=> out_vidx == $past(out_vidx) && out_vd == $past(out_vd));
   // R5: mask use follows the accepted instruction
   a_r5_mask_follow: assert property (@(posedge clk) disable iff (!rst_n)
      start_w |=> out_vmask_vld == $past(in_mask_en));
   // R6: done only on a destination's last micro-op, followed by idle
   a_r6_done_last: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> out_last ##1 !out_valid);
   // R8: a busy sequencer refuses input
   a_r8_no_accept: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !done) |=> busy);
endmodule

// File: tb/gather_useq_tb.sv
module gather_useq_tb_top;
   localparam int CLK_PERIOD = 10;
   localparam int NVEC = 8;
   // {pair, mask, lmul[1:0], vd[4:0], vs[4:0], vi[4:0], stall}
   localparam logic [19:0] VEC [NVEC] = '{
      {1'b0, 1'b0, 2'd0, 5'd4,  5'd8,  5'd12, 1'b0},
      {1'b0, 1'b1, 2'd2, 5'd20, 5'd8,  5'd4,  1'b1},
      {1'b0, 1'b0, 2'd3, 5'd24, 5'd16, 5'd8,  1'b0},
      {1'b0, 1'b0, 2'd1, 5'd30, 5'd31, 5'd2,  1'b1},
      {1'b1, 1'b1, 2'd2, 5'd16, 5'd0,  5'd8,  1'b0},
      {1'b1, 1'b0, 2'd0, 5'd3,  5'd5,  5'd7,  1'b1},
      {1'b1, 1'b0, 2'd3, 5'd28, 5'd8,  5'd16, 1'b1},
      {1'b0, 1'b1, 2'd3, 5'd28, 5'd20, 5'd0,  1'b0}
   };

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #(CLK_PERIOD/2) clk = ~clk;

   logic       sel = 1'b0;
   logic       vld_s = 1'b0, vld_p = 1'b0, o_rdy = 1'b0;
   logic [4:0] i_vd = '0, i_vs = '0, i_vi = '0;
   logic [1:0] i_lm = '0;
   logic       i_mk = 1'b0;

   logic       s_ir, s_ov, s_v1v, s_mv, s_fi, s_la, s_bz, s_dn;
   logic [4:0] s_vd, s_v0, s_v1, s_vx, s_vo, s_vm;
   logic [2:0] s_sl;
   logic       p_ir, p_ov, p_v1v, p_mv, p_fi, p_la, p_bz, p_dn;
   logic [4:0] p_vd, p_v0, p_v1, p_vx, p_vo, p_vm;
   logic [2:0] p_sl;

   gather_useq #(.PAIR_SRC(1'b0)) dut_i (
      .clk(clk), .rst_n(rst_n), .in_valid(vld_s), .in_ready(s_ir), .in_vd(i_vd), .in_vs(i_vs),
      .in_vi(i_vi), .in_lmul(i_lm), .in_mask_en(i_mk), .out_valid(s_ov), .out_ready(o_rdy),
      .out_vd(s_vd), .out_vs0(s_v0), .out_vs1(s_v1), .out_vs1_vld(s_v1v), .out_vidx(s_vx),
      .out_vold(s_vo), .out_vmask(s_vm), .out_vmask_vld(s_mv), .out_slice(s_sl),
      .out_first(s_fi), .out_last(s_la), .busy(s_bz), .done(s_dn));

   gather_useq #(.PAIR_SRC(1'b1)) dut_pair_i (
      .clk(clk), .rst_n(rst_n), .in_valid(vld_p), .in_ready(p_ir), .in_vd(i_vd), .in_vs(i_vs),
      .in_vi(i_vi), .in_lmul(i_lm), .in_mask_en(i_mk), .out_valid(p_ov), .out_ready(o_rdy),
      .out_vd(p_vd), .out_vs0(p_v0), .out_vs1(p_v1), .out_vs1_vld(p_v1v), .out_vidx(p_vx),
      .out_vold(p_vo), .out_vmask(p_vm), .out_vmask_vld(p_mv), .out_slice(p_sl),
      .out_first(p_fi), .out_last(p_la), .busy(p_bz), .done(p_dn));

   logic       m_ir, m_ov, m_v1v, m_mv, m_fi, m_la, m_bz, m_dn;
   logic [4:0] m_vd, m_v0, m_v1, m_vx, m_vo, m_vm;
   logic [2:0] m_sl;
   assign m_ir = sel ? p_ir : s_ir;   assign m_ov = sel ? p_ov : s_ov;
   assign m_v1v = sel ? p_v1v : s_v1v; assign m_mv = sel ? p_mv : s_mv;
   assign m_fi = sel ? p_fi : s_fi;   assign m_la = sel ? p_la : s_la;
   assign m_bz = sel ? p_bz : s_bz;   assign m_dn = sel ? p_dn : s_dn;
   assign m_vd = sel ? p_vd : s_vd;   assign m_v0 = sel ? p_v0 : s_v0;
   assign m_v1 = sel ? p_v1 : s_v1;   assign m_vx = sel ? p_vx : s_vx;
   assign m_vo = sel ? p_vo : s_vo;   assign m_vm = sel ? p_vm : s_vm;
   assign m_sl = sel ? p_sl : s_sl;

   int checks = 0;
   int failures = 0;
   int cyc = 0;
   bit finished = 1'b0;

   always @(posedge clk) begin
      cyc <= cyc + 1;
      if (cyc > 50000 && !finished) begin
         failures++;
         $display("FAIL watchdog: run hung, actual cycles=%0d expected < 50000", cyc);
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   // Run one instruction; optionally pulse a stray instruction while busy (R8)
   task automatic run_one(input logic [19:0] e, input bit stray);
      bit pair, mk, stall;
      int n, step, total, idx, guard, d, s;
      bit seen_done, held_pending;
      logic [4:0] bvd, bvs, bvi, hold_vd, hold_v0;
      logic [2:0] hold_sl;
      pair = e[19]; mk = e[18]; n = 1 << e[17:16];
      bvd = e[15:11]; bvs = e[10:6]; bvi = e[5:1]; stall = e[0];
      step = pair ? 2 : 1;
      total = n * ((n + step - 1) / step);
      @(negedge clk);
      sel = pair; i_vd = bvd; i_vs = bvs; i_vi = bvi; i_lm = e[17:16]; i_mk = mk;
      o_rdy = 1'b0;
      #1;
      chk(m_ir == 1'b1, "R8 idle in_ready", int'(m_ir), 1);
      if (pair) vld_p = 1'b1; else vld_s = 1'b1;
      @(negedge clk);
      vld_p = 1'b0; vld_s = 1'b0;
      chk(m_bz && !m_ir, "R8 busy after accept", int'(m_ir), 0);
      idx = 0; guard = 0; d = 0; s = 0; seen_done = 1'b0; held_pending = 1'b0;
      while (idx < total && guard < 1000) begin
         if (stray && guard == 2) begin
            i_vd = 5'd9; i_vs = 5'd9; i_vi = 5'd9; i_lm = 2'd3;
            if (pair) vld_p = 1'b1; else vld_s = 1'b1;
         end else begin
            vld_p = 1'b0; vld_s = 1'b0;
         end
         o_rdy = stall ? ((guard % 3) != 1) : 1'b1;
         #1;
         if (held_pending) begin
            chk(m_vd == hold_vd && m_v0 == hold_v0 && m_sl == hold_sl, "R7 stall hold",
                int'(m_v0), int'(hold_v0));
            held_pending = 1'b0;
         end
         if (m_ov && o_rdy) begin
            chk(m_vd == 5'(bvd + d) && m_sl == 3'(s) && m_v0 == 5'(bvs + s),
                "R2/R10 order", int'(m_v0), int'(5'(bvs + s)));
            chk(m_vx == 5'(bvi + d), "R3 index", int'(m_vx), int'(5'(bvi + d)));
            chk(m_vo == m_vd, "R4 old dest", int'(m_vo), int'(m_vd));
            chk(m_mv == mk && (!mk || m_vm == 5'd0), "R5 mask", int'(m_mv), int'(mk));
            chk(m_fi == (s == 0) && m_la == (s + step >= n), "R6 first/last",
                int'({m_fi, m_la}), int'({s == 0, s + step >= n}));
            if (pair) chk(m_v1v == (s + 1 < n) && (!(s + 1 < n) || m_v1 == 5'(bvs + s + 1)),
                          "R9 second source", int'(m_v1), int'(5'(bvs + s + 1)));
            chk(m_dn == (idx == total - 1), "R1 done timing", int'(m_dn), int'(idx == total - 1));
            if (m_dn) seen_done = 1'b1;
            idx++;
            s += step;
            if (s >= n) begin s = 0; d++; end
         end else if (m_ov) begin
            hold_vd = m_vd; hold_v0 = m_v0; hold_sl = m_sl; held_pending = 1'b1;
         end
         guard++;
         @(negedge clk);
      end
      vld_p = 1'b0; vld_s = 1'b0;
      o_rdy = 1'b1;
      #1;
      chk(idx == total && seen_done, "R1/R9 uop count", idx, total);
      chk(!m_ov && m_ir, "R8 idle after last", int'(m_ov), 0);
      repeat (2) @(negedge clk);
      chk(!m_ov, "R8 stray pulse ignored", int'(m_ov), 0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      chk(!s_ov && !s_bz && !s_dn && s_ir, "R11 reset single", int'(s_ov), 0);
      chk(!p_ov && !p_bz && !p_dn && p_ir, "R11 reset paired", int'(p_ov), 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(!s_ov && s_ir && !p_ov && p_ir, "R11 after release", int'(s_ov), 0);
      for (int k = 0; k < NVEC; k++) run_one(VEC[k], 1'b0);
      // Directed R8: stray instruction during a running stream
      run_one({1'b0, 1'b0, 2'd1, 5'd10, 5'd12, 5'd14, 1'b1}, 1'b1);
      run_one({1'b1, 1'b1, 2'd1, 5'd31, 5'd30, 5'd29, 1'b0}, 1'b1);
      // Directed R7: long stall at the first micro-op
      @(negedge clk);
      sel = 1'b0; i_vd = 5'd1; i_vs = 5'd2; i_vi = 5'd3; i_lm = 2'd1; i_mk = 1'b0;
      o_rdy = 1'b0; vld_s = 1'b1;
      @(negedge clk);
      vld_s = 1'b0;
      repeat (5) @(negedge clk);
      chk(s_ov && s_vd == 5'd1 && s_v0 == 5'd2 && s_sl == 3'd0, "R7 long stall", int'(s_v0), 2);
      o_rdy = 1'b1;
      repeat (4) @(negedge clk);
      chk(!s_ov && s_ir, "R1 drained after stall", int'(s_ov), 0);
      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule